// File: doc/BRIEF.md
# Peripheral Handshake and Interrupt Controller

This block manages the two control lines that sit beside one peripheral data port. The first line is always an input. A programmed edge on it raises interrupt flag 0. The second line is either a plain interrupt input that raises flag 1, or an output that the block drives by itself. As an output it carries one half of a data handshake with the peripheral.

In a read handshake, the processor reading the port data register drives the output low to signal that the data has been taken. The peripheral's next data-ready edge on the first line releases the output. In a write handshake, a processor write to the port data register drives the output low to signal that data is ready. The peripheral's data-taken edge on the first line releases the output. Either handshake can hold a level or emit a single-cycle low pulse. The parameter `RD_HS_EN` selects the variant: with it set, both handshake directions are available; with it cleared, only the write handshake exists.

The processor sees the block through strobes. There are read and write strobes for the port data register, a write strobe for the flag bits (writing a 1 clears a flag) and a write strobe for the enable bits. An active-low interrupt output summarises the enabled flags.

Top module: `pctl_handshake`

## Requirements
- R1: Synchronous reset clears both flags and both enables, holds `irq_n` high and `ctl2_out` high, and with `mode_sel` = 0 `ctl2_oe` is 0.
- R2: An edge on `ctl1_in` of the polarity picked by `edge_rise[0]` (1 = rising, 0 = falling) sets `flags_o[0]` on the third rising clock edge after the input changes; an edge of the other polarity sets nothing.
- R3: With `mode_sel` = 0 (input mode), `ctl2_oe` is 0 and an edge on `ctl2_in` of the polarity picked by `edge_rise[1]` sets `flags_o[1]`, with the same latency as R2.
- R4: `irq_n` is 0 exactly when some bit of `flags_o` is 1 and the same bit of `en_o` is 1; `en_wr_stb` loads `en_wr_data` into `en_o`.
- R5: `flag_wr_stb` clears each flag whose `flag_wr_data` bit is 1 and leaves the flags whose bit is 0; a set arriving in the same cycle wins.
- R6: A `port_rd_stb` or `port_wr_stb` pulse clears `flags_o[0]` and leaves `flags_o[1]` unchanged.
- R7: With `mode_sel` = 1 (read handshake, level), `port_rd_stb` drives `ctl2_out` low from the next cycle; it stays low until an active `ctl1_in` edge, and it returns high in the same cycle that this edge sets `flags_o[0]`.
- R8: With `mode_sel` = 2 (read handshake, pulse), `port_rd_stb` drives `ctl2_out` low for exactly one cycle.
- R9: With `mode_sel` = 3 (write handshake, level), `port_wr_stb` drives `ctl2_out` low until an active `ctl1_in` edge, and it returns high in the same cycle that this edge sets `flags_o[0]`.
- R10: With `mode_sel` = 4 (write handshake, pulse), `port_wr_stb` drives `ctl2_out` low for exactly one cycle.
- R11: With `RD_HS_EN` = 0, modes 1 and 2 behave as input mode: `ctl2_oe` is 0, `ctl2_out` stays high and `ctl2_in` edges set `flags_o[1]`. Modes 3 and 4 behave as in R9 and R10.
- R12: In modes 1 to 4, `ctl2_oe` is 1, edges on `ctl2_in` do not set `flags_o[1]`, and the strobe of the other direction does not drive `ctl2_out`. Modes 5 to 7 behave as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Second-line mode: 0 input, 1 read level, 2 read pulse, 3 write level, 4 write pulse |
| edge_rise | input | 2 | Per-line active edge: bit 0 for line 1, bit 1 for line 2; 1 rising, 0 falling |
| ctl1_in | input | 1 | First control line (always input) |
| ctl2_in | input | 1 | Second control line, input value |
| port_rd_stb | input | 1 | Processor read of the port data register |
| port_wr_stb | input | 1 | Processor write of the port data register |
| flag_wr_stb | input | 1 | Flag write strobe (write 1 to clear) |
| flag_wr_data | input | 2 | Flag clear mask |
| en_wr_stb | input | 1 | Enable write strobe |
| en_wr_data | input | 2 | New enable bits |
| flags_o | output | 2 | Interrupt flags, bit 0 line 1, bit 1 line 2 |
| en_o | output | 2 | Interrupt enables |
| ctl2_out | output | 1 | Second control line, driven value |
| ctl2_oe | output | 1 | Second control line output enable |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench samples the flag both one cycle before and at the cycle when the synchroniser latency makes it visible. A design with a missing or extra stage then fails on timing, not only on value. In level modes the bench holds the output low across several idle cycles and a wrong-direction strobe. It then checks that the output is released in exactly the cycle of the first-line edge. A design that releases early, or that answers the other strobe, shows up there. Pulse modes are checked for a low of exactly one cycle. A B-variant instance runs beside the A-variant one and shows that read modes fall back to input behaviour. Flag tests cover clearing by write-1, a 0 in the mask leaving a flag alone, and port access clearing only the first-line flag.

// File: rtl/hs_pkg.sv
package hs_pkg;

    localparam int NLINES = 2;

    typedef enum logic [2:0] {
        HM_INPUT    = 3'd0,
        HM_RD_LEVEL = 3'd1,
        HM_RD_PULSE = 3'd2,
        HM_WR_LEVEL = 3'd3,
        HM_WR_PULSE = 3'd4
    } hs_mode_e;

    typedef struct packed {
        logic drive;    // second line is an output
        logic on_read;  // triggered by port read (else by port write)
        logic pulse;    // single-cycle low instead of level
    } hs_ctl_t;

    function automatic hs_ctl_t hs_decode(input logic [2:0] raw, input logic rd_ok);
        hs_ctl_t c;
        c = '0;
        case (raw)
            HM_RD_LEVEL: if (rd_ok) c = '{drive: 1'b1, on_read: 1'b1, pulse: 1'b0};
            HM_RD_PULSE: if (rd_ok) c = '{drive: 1'b1, on_read: 1'b1, pulse: 1'b1};
            HM_WR_LEVEL: c = '{drive: 1'b1, on_read: 1'b0, pulse: 1'b0};
            HM_WR_PULSE: c = '{drive: 1'b1, on_read: 1'b0, pulse: 1'b1};
            default:     c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/hs_sync_edge.sv
module hs_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic rise_sel,
    output logic edge_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[DEPTH-2:0], din};
        end
    end

    // pipe[STAGES-1] is the synchronised value, pipe[STAGES] its previous value
    assign edge_o = rise_sel ? ( pipe[STAGES-1] & ~pipe[STAGES])
                             : (~pipe[STAGES-1] &  pipe[STAGES]);
endmodule

// File: rtl/hs_out_ctl.sv
module hs_out_ctl
    import hs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  hs_ctl_t ctl,
    input  logic    rd_stb,
    input  logic    wr_stb,
    input  logic    done_edge,
    output logic    line_q,
    output logic    line_oe
);
    logic trigger;

    assign trigger = ctl.drive & (ctl.on_read ? rd_stb : wr_stb);

    always_ff @(posedge clk) begin
        if (rst || !ctl.drive) begin
            line_q <= 1'b1;
        end else if (trigger) begin
            line_q <= 1'b0;
        end else if (ctl.pulse || done_edge) begin
            line_q <= 1'b1;
        end
    end

    assign line_oe = ctl.drive;
endmodule

// File: rtl/pctl_handshake.sv
module pctl_handshake
    import hs_pkg::*;
#(
    parameter bit RD_HS_EN    = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_sel,
    input  logic [NLINES-1:0] edge_rise,
    input  logic              ctl1_in,
    input  logic              ctl2_in,
    input  logic              port_rd_stb,
    input  logic              port_wr_stb,
    input  logic              flag_wr_stb,
    input  logic [NLINES-1:0] flag_wr_data,
    input  logic              en_wr_stb,
    input  logic [NLINES-1:0] en_wr_data,
    output logic [NLINES-1:0] flags_o,
    output logic [NLINES-1:0] en_o,
    output logic              ctl2_out,
    output logic              ctl2_oe,
    output logic              irq_n
);
    hs_ctl_t           ctl;
    logic [NLINES-1:0] line_in;
    logic [NLINES-1:0] raw_edge;
    logic [NLINES-1:0] edge_hit;
    logic [NLINES-1:0] flag_q, en_q, clr_mask;

    assign ctl     = hs_decode(mode_sel, RD_HS_EN);
    assign line_in = {ctl2_in, ctl1_in};

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        hs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst      (rst),
            .din      (line_in[i]),
            .rise_sel (edge_rise[i]),
            .edge_o   (raw_edge[i])
        );
    end

    // second line only raises its flag while it is an input
    assign edge_hit = {raw_edge[1] & ~ctl.drive, raw_edge[0]};

    assign clr_mask = (flag_wr_stb ? flag_wr_data : '0)
                    | {1'b0, port_rd_stb | port_wr_stb};

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            en_q   <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_mask) | edge_hit;
            if (en_wr_stb) begin
                en_q <= en_wr_data;
            end
        end
    end

    hs_out_ctl u_out (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .rd_stb    (port_rd_stb),
        .wr_stb    (port_wr_stb),
        .done_edge (raw_edge[0]),
        .line_q    (ctl2_out),
        .line_oe   (ctl2_oe)
    );

    assign flags_o = flag_q;
    assign en_o    = en_q;
    assign irq_n   = ~|(flag_q & en_q);
endmodule

// File: rtl/pctl_handshake_chk.sv
module pctl_handshake_chk #(
    parameter bit RD_HS_EN = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] mode_sel,
    input logic       port_rd_stb,
    input logic       port_wr_stb,
    input logic       flag_wr_stb,
    input logic [1:0] flag_wr_data,
    input logic [1:0] edge_hit,
    input logic [1:0] flags_o,
    input logic [1:0] en_o,
    input logic       ctl2_out,
    input logic       ctl2_oe,
    input logic       irq_n
);
    logic rd_mode, rd_pulse, wr_mode, wr_pulse;
    assign rd_mode  = RD_HS_EN && (mode_sel == 3'd1 || mode_sel == 3'd2);
    assign rd_pulse = RD_HS_EN && (mode_sel == 3'd2);
    assign wr_mode  = (mode_sel == 3'd3 || mode_sel == 3'd4);
    assign wr_pulse = (mode_sel == 3'd4);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (flags_o == 2'b00 && en_o == 2'b00 && irq_n && ctl2_out)); // R1

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
        edge_hit[0] |=> flags_o[0]); // R2

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (en_o == 2'b00) |-> irq_n); // R4

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (flag_wr_stb && flag_wr_data[1] && !edge_hit[1]) |=> !flags_o[1]); // R5

    AST_PORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ((port_rd_stb || port_wr_stb) && !edge_hit[0]) |=> !flags_o[0]); // R6

    AST_RD_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
        (rd_mode && port_rd_stb) |=> !ctl2_out); // R7

    AST_WR_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
        (wr_mode && port_wr_stb) |=> !ctl2_out); // R9

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ((wr_pulse || rd_pulse) && !ctl2_out && !port_rd_stb && !port_wr_stb)
        |=> ctl2_out); // R10

    AST_DRIVE_NO_FLAG2: assert property (@(posedge clk) disable iff (rst)
        (ctl2_oe && !flags_o[1]) |=> !flags_o[1]); // R12
endmodule

bind pctl_handshake pctl_handshake_chk #(.RD_HS_EN(RD_HS_EN)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_sel     (mode_sel),
    .port_rd_stb  (port_rd_stb),
    .port_wr_stb  (port_wr_stb),
    .flag_wr_stb  (flag_wr_stb),
    .flag_wr_data (flag_wr_data),
    .edge_hit     (edge_hit),
    .flags_o      (flags_o),
    .en_o         (en_o),
    .ctl2_out     (ctl2_out),
    .ctl2_oe      (ctl2_oe),
    .irq_n        (irq_n)
);

// File: tb/pctl_handshake_test.sv
`timescale 1ns/1ps
module pctl_handshake_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode_sel = 3'd0;
    logic [1:0] edge_rise = 2'b11;
    logic       ctl1_in = 1'b0, ctl2_in = 1'b0;
    logic       port_rd_stb = 1'b0, port_wr_stb = 1'b0;
    logic       flag_wr_stb = 1'b0, en_wr_stb = 1'b0;
    logic [1:0] flag_wr_data = 2'b00, en_wr_data = 2'b00;
    logic [1:0] flags_o, en_o, b_flags, b_en;
    logic       ctl2_out, ctl2_oe, irq_n, b_out, b_oe, b_irq_n;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    pctl_handshake #(.RD_HS_EN(1'b1)) uut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .edge_rise(edge_rise),
        .ctl1_in(ctl1_in), .ctl2_in(ctl2_in),
        .port_rd_stb(port_rd_stb), .port_wr_stb(port_wr_stb),
        .flag_wr_stb(flag_wr_stb), .flag_wr_data(flag_wr_data),
        .en_wr_stb(en_wr_stb), .en_wr_data(en_wr_data),
        .flags_o(flags_o), .en_o(en_o), .ctl2_out(ctl2_out),
        .ctl2_oe(ctl2_oe), .irq_n(irq_n));

    pctl_handshake #(.RD_HS_EN(1'b0)) uut_b (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .edge_rise(edge_rise),
        .ctl1_in(ctl1_in), .ctl2_in(ctl2_in),
        .port_rd_stb(port_rd_stb), .port_wr_stb(port_wr_stb),
        .flag_wr_stb(flag_wr_stb), .flag_wr_data(flag_wr_data),
        .en_wr_stb(en_wr_stb), .en_wr_data(en_wr_data),
        .flags_o(b_flags), .en_o(b_en), .ctl2_out(b_out),
        .ctl2_oe(b_oe), .irq_n(b_irq_n));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic strobe_rd();
        port_rd_stb = 1'b1; tick(1); port_rd_stb = 1'b0;
    endtask
    task automatic strobe_wr();
        port_wr_stb = 1'b1; tick(1); port_wr_stb = 1'b0;
    endtask
    task automatic clear_flags(input logic [1:0] m);
        flag_wr_data = m; flag_wr_stb = 1'b1; tick(1); flag_wr_stb = 1'b0;
    endtask
    // settle line 1 low, then raise it at a falling clock edge
    task automatic rise1();
        ctl1_in = 1'b0; tick(4); ctl1_in = 1'b1;
    endtask
    task automatic rise2();
        ctl2_in = 1'b0; tick(4); ctl2_in = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 flags", {2'b0, flags_o}, 4'h0);
        chk("R1 enables", {2'b0, en_o}, 4'h0);
        chk("R1 irq_n/out/oe", {1'b0, irq_n, ctl2_out, ctl2_oe}, 4'b0110);
    endtask

    task automatic t_line1_edges();
        mode_sel = 3'd0; edge_rise = 2'b11;
        rise1(); tick(2);
        chk("R2 flag0 not yet", {3'b0, flags_o[0]}, 4'h0);
        tick(1);
        chk("R2 flag0 on rising", {3'b0, flags_o[0]}, 4'h1);
        clear_flags(2'b10);
        chk("R5 zero mask keeps", {3'b0, flags_o[0]}, 4'h1);
        clear_flags(2'b01);
        chk("R5 one mask clears", {3'b0, flags_o[0]}, 4'h0);
        edge_rise[0] = 1'b0;
        ctl1_in = 1'b0; tick(4);
        chk("R2 falling sets", {3'b0, flags_o[0]}, 4'h1);
        clear_flags(2'b01);
        ctl1_in = 1'b1; tick(4);
        chk("R2 wrong polarity ignored", {3'b0, flags_o[0]}, 4'h0);
        edge_rise[0] = 1'b1; tick(2);
    endtask

    task automatic t_line2_input();
        mode_sel = 3'd0; clear_flags(2'b11);
        rise2(); tick(3);
        chk("R3 flag1 set, oe low", {2'b0, flags_o[1], ctl2_oe}, 4'b0010);
        clear_flags(2'b10);
        mode_sel = 3'd6; tick(1);
        chk("R12 mode 6 oe", {3'b0, ctl2_oe}, 4'h0);
        rise2(); tick(3);
        chk("R12 mode 6 acts as input", {3'b0, flags_o[1]}, 4'h1);
        mode_sel = 3'd0;
    endtask

    task automatic t_irq_and_port();
        en_wr_data = 2'b01; en_wr_stb = 1'b1; tick(1); en_wr_stb = 1'b0;
        chk("R4 enable loaded", {2'b0, en_o}, 4'h1);
        rise1(); tick(3);
        chk("R4 irq asserted", {3'b0, irq_n}, 4'h0);
        en_wr_data = 2'b00; en_wr_stb = 1'b1; tick(1); en_wr_stb = 1'b0;
        chk("R4 irq masked", {3'b0, irq_n}, 4'h1);
        strobe_rd();
        chk("R6 read clears flag0 only", {2'b0, flags_o}, 4'h2);
        rise1(); tick(3);
        strobe_wr();
        chk("R6 write clears flag0 only", {2'b0, flags_o}, 4'h2);
        clear_flags(2'b11);
    endtask

    task automatic t_rd_level();
        mode_sel = 3'd1; tick(1);
        chk("R12 read mode oe", {2'b0, ctl2_oe, ctl2_out}, 4'b0011);
        chk("R11 B read mode input", {2'b0, b_oe, b_out}, 4'b0001);
        ctl1_in = 1'b0; tick(4);
        strobe_rd();
        chk("R7 out low after read", {3'b0, ctl2_out}, 4'h0);
        tick(3);
        strobe_wr();
        chk("R12 write strobe ignored", {3'b0, ctl2_out}, 4'h0);
        clear_flags(2'b11);
        rise2(); tick(4);
        chk("R12 no flag1 while driving", {3'b0, flags_o[1]}, 4'h0);
        chk("R11 B flag1 from line2", {3'b0, b_flags[1]}, 4'h1);
        chk("R11 B out stays high", {3'b0, b_out}, 4'h1);
        ctl1_in = 1'b1; tick(2);
        chk("R7 still low before edge", {3'b0, ctl2_out}, 4'h0);
        tick(1);
        chk("R7 released with flag0", {2'b0, flags_o[0], ctl2_out}, 4'b0011);
        clear_flags(2'b11);
    endtask

    task automatic t_rd_pulse();
        mode_sel = 3'd2; tick(1);
        strobe_rd();
        chk("R8 pulse low", {3'b0, ctl2_out}, 4'h0);
        tick(1);
        chk("R8 pulse one cycle", {3'b0, ctl2_out}, 4'h1);
        chk("R11 B no read pulse", {3'b0, b_out}, 4'h1);
    endtask

    task automatic t_wr_level();
        mode_sel = 3'd3; ctl1_in = 1'b0; tick(4);
        strobe_wr();
        chk("R9 out low after write", {3'b0, ctl2_out}, 4'h0);
        chk("R11 B write handshake", {2'b0, b_oe, b_out}, 4'b0010);
        strobe_rd();
        tick(2);
        chk("R12 read strobe no release", {3'b0, ctl2_out}, 4'h0);
        ctl1_in = 1'b1; tick(2);
        chk("R9 still low before edge", {3'b0, ctl2_out}, 4'h0);
        tick(1);
        chk("R9 released with flag0", {2'b0, flags_o[0], ctl2_out}, 4'b0011);
        clear_flags(2'b11);
    endtask

    task automatic t_wr_pulse();
        mode_sel = 3'd4; tick(1);
        chk("R10 idle high", {3'b0, ctl2_out}, 4'h1);
        strobe_wr();
        chk("R10 pulse low", {2'b0, ctl2_out, b_out}, 4'h0);
        tick(1);
        chk("R10 pulse one cycle", {2'b0, ctl2_out, b_out}, 4'h3);
        mode_sel = 3'd0;
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_line1_edges();
        t_line2_input();
        t_irq_and_port();
        t_rd_level();
        t_rd_pulse();
        t_wr_level();
        t_wr_pulse();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired, actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule